// File: doc/BRIEF.md
# Core Power Domain Sequencer

This block sequences the power of a single processor core domain. Software writes a 2-bit target field to ask for the domain to be on or off. The block then steps the power switch enable, the isolation clamp and the core reset in a fixed order. A read-only 2-bit status code tells software whether the domain is settled on, settled off, or partway through a transition in either direction.

A request to turn the domain off is held until the core reports that it is idle in wait-for-interrupt. Only then does any power-down action start. The block reacts to a change in the target field, not to its level. A switch-on request that arrives while a switch-off is pending or running always wins, in the order the requests were written. If the core has not yet gone idle, the switch-off is dropped and the switch is never touched. If the switch-off is already running, it runs to the off state first, and the switch-on sequence then starts without further action from software.

Top module: `core_pwr_seq`

## Requirements
- R1: After reset the domain is on. Status is 3 (binary 11), switch enable is 1, isolation is 0 and core reset is 0. The target field holds 3.
- R2: Writing 0 to the target field while the domain is on sets status to 1 (powering down). This happens on the clock edge after the edge that captures the write.
- R3: While a power-down waits for the idle signal, switch enable, isolation and core reset do not change.
- R4: Power-down order: core reset asserts on the edge that first samples the idle signal high. Isolation asserts on the next edge. Switch enable drops two edges after isolation. Status becomes 0 on the first edge that samples the switch acknowledge low.
- R5: Writing 3 while the domain is off sets switch enable and status 2 (powering up) on the edge after capture. Isolation releases four edges after the edge that first samples the acknowledge high. Core reset releases one edge later, and status becomes 3 one edge after that.
- R6: Writing 3 while still waiting for the idle signal cancels the power-down. Status returns to 3 on the edge after capture, and switch enable never drops.
- R7: Writing 3 during a running power-down lets it finish to status 0, held for one cycle. The power-up sequence then begins on the next edge with no further write.
- R8: Writes of 1 or 2 to the target field are ignored. A write of the value already held is also ignored. Neither starts a sequence nor changes status.
- R9: Status 3 is shown only when the switch is on and isolation and reset are released. Status 0 is shown only when the switch is off and isolation and reset are asserted. Whenever switch enable is low, isolation and reset are both asserted. Status never steps directly between 3 and 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWrEn | input | 1 | Write strobe for the target field |
| cfgWrData | input | 2 | Value written to the target field (3 = on, 0 = off) |
| coreWfi | input | 1 | Core is idle in wait-for-interrupt |
| swAck | input | 1 | Power switch acknowledge, follows switch enable |
| swEn | output | 1 | Power switch enable |
| isoEn | output | 1 | Output isolation clamp enable |
| coreRst | output | 1 | Core reset, active high |
| status | output | 2 | 3 on, 0 off, 1 powering down, 2 powering up |

## Verification
Every result is due a fixed number of clock edges after its trigger. A write is captured on one edge and the status reacts on the next. The idle signal gives reset at once, then isolation one edge later and the switch two edges after that. The acknowledge gives the status change on the edge that samples it, or the isolation release four edges later. The directed checks drive each input on a falling edge and step an exact number of falling edges before sampling, so each output is read half a cycle after the edge that must change it. The random phase models the switch acknowledge with a random lag. It checks the settled-state relations on every cycle, and checks the final state against the last valid write once the core is held idle.

// File: rtl/core_pwr_seq_pkg.sv
package core_pwr_seq_pkg;

  localparam logic [1:0] STAT_OFF     = 2'b00;
  localparam logic [1:0] STAT_GOINGDN = 2'b01;
  localparam logic [1:0] STAT_GOINGUP = 2'b10;
  localparam logic [1:0] STAT_ON      = 2'b11;

  typedef enum logic [3:0] {
    ST_ON,
    ST_WAIT_IDLE,
    ST_DN_RST,
    ST_DN_HOLD,
    ST_DN_SWOFF,
    ST_OFF,
    ST_UP_SWON,
    ST_UP_SETTLE,
    ST_UP_ISOREL,
    ST_UP_RSTREL
  } seqState_e;

  typedef struct packed {
    logic       rstSet;
    logic       rstClr;
    logic       isoSet;
    logic       isoClr;
    logic       swSet;
    logic       swClr;
    logic       loadDnHold;
    logic       loadUpSettle;
    logic       cntDec;
    logic       statWr;
    logic [1:0] statCode;
  } seqStrobe_t;

endpackage

// File: rtl/core_pwr_seq_ctrl.sv
module core_pwr_seq_ctrl
  import core_pwr_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgOn,
  input  logic       cfgOff,
  input  logic       cntZero,
  input  logic       coreWfi,
  input  logic       swAck,
  output seqStrobe_t strobe
);

  seqState_e stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_ON;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    unique case (stateQ)
      ST_ON: begin
        if (cfgOff) begin
          stateD          = ST_WAIT_IDLE;
          strobe.statWr   = 1'b1;
          strobe.statCode = STAT_GOINGDN;
        end
      end
      ST_WAIT_IDLE: begin
        if (cfgOn) begin
          stateD          = ST_ON;
          strobe.statWr   = 1'b1;
          strobe.statCode = STAT_ON;
        end else if (coreWfi) begin
          stateD        = ST_DN_RST;
          strobe.rstSet = 1'b1;
        end
      end
      ST_DN_RST: begin
        stateD            = ST_DN_HOLD;
        strobe.isoSet     = 1'b1;
        strobe.loadDnHold = 1'b1;
      end
      ST_DN_HOLD: begin
        if (cntZero) begin
          stateD       = ST_DN_SWOFF;
          strobe.swClr = 1'b1;
        end else begin
          strobe.cntDec = 1'b1;
        end
      end
      ST_DN_SWOFF: begin
        if (!swAck) begin
          stateD          = ST_OFF;
          strobe.statWr   = 1'b1;
          strobe.statCode = STAT_OFF;
        end
      end
      ST_OFF: begin
        if (cfgOn) begin
          stateD          = ST_UP_SWON;
          strobe.swSet    = 1'b1;
          strobe.statWr   = 1'b1;
          strobe.statCode = STAT_GOINGUP;
        end
      end
      ST_UP_SWON: begin
        if (swAck) begin
          stateD              = ST_UP_SETTLE;
          strobe.loadUpSettle = 1'b1;
        end
      end
      ST_UP_SETTLE: begin
        if (cntZero) begin
          stateD        = ST_UP_ISOREL;
          strobe.isoClr = 1'b1;
        end else begin
          strobe.cntDec = 1'b1;
        end
      end
      ST_UP_ISOREL: begin
        stateD        = ST_UP_RSTREL;
        strobe.rstClr = 1'b1;
      end
      ST_UP_RSTREL: begin
        stateD          = ST_ON;
        strobe.statWr   = 1'b1;
        strobe.statCode = STAT_ON;
      end
      default: stateD = ST_ON;
    endcase
  end

endmodule

// File: rtl/core_pwr_seq_dp.sv
module core_pwr_seq_dp
  import core_pwr_seq_pkg::*;
#(
  parameter int DN_HOLD_CYC   = 2,
  parameter int UP_SETTLE_CYC = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWrEn,
  input  logic [1:0] cfgWrData,
  input  seqStrobe_t strobe,
  output logic       cfgOn,
  output logic       cfgOff,
  output logic       cntZero,
  output logic       swEn,
  output logic       isoEn,
  output logic       coreRst,
  output logic [1:0] status
);

  localparam int MAX_WAIT = (DN_HOLD_CYC > UP_SETTLE_CYC) ? DN_HOLD_CYC : UP_SETTLE_CYC;
  localparam int CNT_W    = (MAX_WAIT > 1) ? $clog2(MAX_WAIT) : 1;
  localparam logic [CNT_W-1:0] DN_LOAD = CNT_W'(DN_HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] UP_LOAD = CNT_W'(UP_SETTLE_CYC - 1);

  logic [1:0]       cfgQ;
  logic [CNT_W-1:0] cntQ;
  logic             validWr;

  assign validWr = cfgWrEn && ((cfgWrData == STAT_ON) || (cfgWrData == STAT_OFF));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        cfgQ <= STAT_ON;
    else if (validWr) cfgQ <= cfgWrData;
  end

  assign cfgOn  = (cfgQ == STAT_ON);
  assign cfgOff = (cfgQ == STAT_OFF);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    cntQ <= '0;
    else if (strobe.loadDnHold)   cntQ <= DN_LOAD;
    else if (strobe.loadUpSettle) cntQ <= UP_LOAD;
    else if (strobe.cntDec)       cntQ <= cntQ - 1'b1;
  end

  assign cntZero = (cntQ == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      swEn    <= 1'b1;
      isoEn   <= 1'b0;
      coreRst <= 1'b0;
      status  <= STAT_ON;
    end else begin
      if (strobe.swSet)       swEn    <= 1'b1;
      else if (strobe.swClr)  swEn    <= 1'b0;
      if (strobe.isoSet)      isoEn   <= 1'b1;
      else if (strobe.isoClr) isoEn   <= 1'b0;
      if (strobe.rstSet)      coreRst <= 1'b1;
      else if (strobe.rstClr) coreRst <= 1'b0;
      if (strobe.statWr)      status  <= strobe.statCode;
    end
  end

endmodule

// File: rtl/core_pwr_seq.sv
module core_pwr_seq
  import core_pwr_seq_pkg::*;
#(
  parameter int DN_HOLD_CYC   = 2,
  parameter int UP_SETTLE_CYC = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWrEn,
  input  logic [1:0] cfgWrData,
  input  logic       coreWfi,
  input  logic       swAck,
  output logic       swEn,
  output logic       isoEn,
  output logic       coreRst,
  output logic [1:0] status
);

  seqStrobe_t strobe;
  logic       cfgOn, cfgOff, cntZero;

  core_pwr_seq_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cfgOn   (cfgOn),
    .cfgOff  (cfgOff),
    .cntZero (cntZero),
    .coreWfi (coreWfi),
    .swAck   (swAck),
    .strobe  (strobe)
  );

  core_pwr_seq_dp #(
    .DN_HOLD_CYC   (DN_HOLD_CYC),
    .UP_SETTLE_CYC (UP_SETTLE_CYC)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrEn   (cfgWrEn),
    .cfgWrData (cfgWrData),
    .strobe    (strobe),
    .cfgOn     (cfgOn),
    .cfgOff    (cfgOff),
    .cntZero   (cntZero),
    .swEn      (swEn),
    .isoEn     (isoEn),
    .coreRst   (coreRst),
    .status    (status)
  );

endmodule

// File: rtl/core_pwr_seq_chk.sv
module core_pwr_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       coreWfi,
  input logic       swAck,
  input logic       swEn,
  input logic       isoEn,
  input logic       coreRst,
  input logic [1:0] status
);

  // R9: settled-on code only with the domain fully live
  assert_on_code_live_R9: assert property (@(posedge clk) disable iff (!rstN)
    (status == 2'b11) |-> (swEn && !isoEn && !coreRst));

  // R9: switch off always under clamp and reset
  assert_off_clamped_R9: assert property (@(posedge clk) disable iff (!rstN)
    !swEn |-> (isoEn && coreRst));

  // R9: no direct jump between settled codes
  assert_no_direct_jump_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(status) == 2'b11) |-> (status != 2'b00));

  assert_no_direct_rise_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(status) == 2'b00) |-> (status != 2'b11));

  // R3: reset of the core starts only after the idle signal was seen
  assert_rst_after_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(coreRst) |-> $past(coreWfi));

  // R4: switch drops only after isolation has been held for two cycles
  assert_sw_after_iso_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(swEn) |-> ($past(isoEn, 2) && coreRst));

  // R5: isolation releases only with the switch on and acknowledged
  assert_iso_rel_powered_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(isoEn) |-> (swEn && swAck && coreRst));

endmodule

bind core_pwr_seq core_pwr_seq_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .coreWfi (coreWfi),
  .swAck   (swAck),
  .swEn    (swEn),
  .isoEn   (isoEn),
  .coreRst (coreRst),
  .status  (status)
);

// File: tb/core_pwr_seq_bench.sv
module core_pwr_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rstN;
  logic       cfgWrEn;
  logic [1:0] cfgWrData;
  logic       coreWfi;
  logic       swAck;
  logic       swEn, isoEn, coreRst;
  logic [1:0] status;

  int tests = 0;
  int fails = 0;
  int ackWait = 0;
  logic [1:0] lastValid = 2'b11;

  always #(CLK_PERIOD/2) clk = ~clk;

  core_pwr_seq u_core_pwr_seq (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .coreWfi(coreWfi), .swAck(swAck), .swEn(swEn), .isoEn(isoEn),
    .coreRst(coreRst), .status(status)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int packOut();
    return {28'd0, swEn, isoEn, coreRst, 1'b0} | int'(status);
  endfunction

  // expected output pattern for a settled state: {swEn,isoEn,coreRst}
  function automatic bit settledOk(input logic [1:0] st);
    if (st == 2'b11) return swEn && !isoEn && !coreRst;
    if (st == 2'b00) return !swEn && isoEn && coreRst;
    return 1'b1;
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrCfg(input logic [1:0] v);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrData = v;
    if (v == 2'b11 || v == 2'b00) lastValid = v;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic ackModel();
    if (swAck != swEn) begin
      if (ackWait == 0) begin
        swAck   = swEn;
        ackWait = $urandom_range(1, 4);
      end else ackWait--;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired (all requirements) actual=%0d expected=%0d", WATCHDOG, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rstN = 1'b0; cfgWrEn = 1'b0; cfgWrData = 2'b00; coreWfi = 1'b0; swAck = 1'b1;
    step(3);
    rstN = 1'b1;
    step(1);
    // R1 reset state
    chk(status == 2'b11 && swEn && !isoEn && !coreRst, "R1 reset state", packOut(), 32'hB);

    // R8 ignored writes
    wrCfg(2'b01); step(3);
    chk(status == 2'b11 && swEn, "R8 write of 1 ignored", status, 3);
    wrCfg(2'b10); step(3);
    chk(status == 2'b11 && swEn && !coreRst, "R8 write of 2 ignored", status, 3);
    wrCfg(2'b11); step(3);
    chk(status == 2'b11, "R8 repeat write ignored", status, 3);

    // R2 / R3
    wrCfg(2'b00);
    chk(status == 2'b11, "R2 status not yet changed on capture edge", status, 3);
    step(1);
    chk(status == 2'b01, "R2 status powering down", status, 1);
    step(5);
    chk(status == 2'b01 && swEn && !isoEn && !coreRst, "R3 no action before idle", packOut(), 32'h9);

    // R4 power-down order
    coreWfi = 1'b1;
    step(1);
    chk(coreRst && !isoEn && swEn, "R4 reset first", packOut(), 32'hB);
    step(1);
    chk(isoEn && swEn, "R4 isolation next", isoEn, 1);
    step(1);
    chk(swEn, "R4 switch held one more cycle", swEn, 1);
    step(1);
    chk(!swEn && status == 2'b01, "R4 switch off", swEn, 0);
    step(2);
    chk(status == 2'b01, "R4 status waits for ack drop", status, 1);
    swAck = 1'b0;
    step(1);
    chk(status == 2'b00, "R4 status off after ack drop", status, 0);
    coreWfi = 1'b0;
    step(3);
    chk(status == 2'b00 && settledOk(status), "R9 off settled", packOut(), 32'h6);

    // R5 power-up order
    wrCfg(2'b11); step(1);
    chk(swEn && status == 2'b10 && isoEn && coreRst, "R5 switch on, status up", status, 2);
    step(3);
    chk(status == 2'b10 && isoEn, "R5 waits for ack", status, 2);
    swAck = 1'b1;
    step(4);
    chk(isoEn, "R5 isolation held through settle", isoEn, 1);
    step(1);
    chk(!isoEn && coreRst && status == 2'b10, "R5 isolation released", isoEn, 0);
    step(1);
    chk(!coreRst && status == 2'b10, "R5 reset released", coreRst, 0);
    step(1);
    chk(status == 2'b11 && settledOk(status), "R5 status on", status, 3);

    // R6 cancel while waiting
    wrCfg(2'b00); step(1);
    chk(status == 2'b01, "R6 pending down", status, 1);
    wrCfg(2'b11);
    chk(status == 2'b01 && swEn, "R6 still pending on capture edge", status, 1);
    step(1);
    chk(status == 2'b11 && swEn && !isoEn && !coreRst, "R6 cancelled without switching", packOut(), 32'hB);

    // R7 on request during active power-down
    wrCfg(2'b00); step(1);
    coreWfi = 1'b1;
    step(2);
    wrCfg(2'b11);
    coreWfi = 1'b0;
    chk(!swEn && status == 2'b01, "R7 down sequence continues", packOut(), 32'h7);
    step(1);
    chk(status == 2'b01, "R7 still powering down", status, 1);
    swAck = 1'b0;
    step(1);
    chk(status == 2'b00, "R7 reaches off", status, 0);
    step(1);
    chk(status == 2'b10 && swEn, "R7 power-up starts automatically", status, 2);
    swAck = 1'b1;
    step(7);
    chk(status == 2'b11 && settledOk(status), "R7 back on", status, 3);

    // random phase
    for (int i = 0; i < 1500; i++) begin
      @(negedge clk);
      ackModel();
      coreWfi = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 9) == 0) begin
        cfgWrEn   = 1'b1;
        cfgWrData = 2'($urandom_range(0, 3));
        if (cfgWrData == 2'b11 || cfgWrData == 2'b00) lastValid = cfgWrData;
      end else cfgWrEn = 1'b0;
      if (!settledOk(status) || (!swEn && !(isoEn && coreRst)))
        chk(1'b0, "R9 random settled relation", packOut(), int'(status));
      if ((i % 100) == 0) chk(settledOk(status), "R9 random sample", packOut(), int'(status));
    end
    @(negedge clk);
    cfgWrEn = 1'b0;
    coreWfi = 1'b1;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      ackModel();
    end
    chk(status == lastValid && settledOk(status), "R7 final state follows last valid write",
        int'(status), int'(lastValid));

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule